// File: doc/BRIEF.md
# Reset Boot Mode Sequencer

This block decides, at the end of system reset, how the processor core leaves reset. While reset is held it keeps capturing a three-bit strap word (C, B, A). When reset is released it turns the last captured value into a memory configuration and a boot method. It then gates the core's run enable until that boot method is satisfied.

There are three boot methods. In the byte-DMA methods the sequencer fires a one-cycle start strobe at a DMA engine, together with a fixed word count of 32, and holds the core until the engine reports completion. In the host-DMA method the core waits until a host write lands on internal program address 0. In the no-boot method the core runs at once from the external start vector. Codes outside the defined set stop the core and raise an error flag.

The DMA datapath is not part of this block. It appears only as a done pulse and a watched host write port.

Top module: `boot_mode_seq`

## Requirements
- R1: `mode_pins` (bit 2 = C, bit 1 = B, bit 0 = A) is captured on every clock edge while `rst` is high. Once `rst` is low, changes on `mode_pins` have no effect on any output.
- R2: `host_mem_mode` equals the captured C bit: 0 means full memory mode and 1 means host memory mode.
- R3: For captured codes CBA = 000 and 100, `dma_start` is high for exactly one cycle, after the first clock edge with `rst` low. `dma_words` is 32.
- R4: In the byte-DMA codes, `core_run` goes high one cycle after the edge that samples `dma_done` high. Host writes have no effect in these codes.
- R5: For code 010, `core_run` and `start_external` go high after the first edge with `rst` low. In this code `dma_start` never pulses, and `dma_done` and host writes have no effect.
- R6: For code 101, `core_run` goes high one cycle after an edge that samples `host_wr_valid` high with `host_wr_pm` = 1 and `host_wr_addr` = 0. Writes to other addresses, writes to data memory, and `dma_done` are ignored.
- R7: For codes 001, 011, 110 and 111, `boot_err` goes high after the first edge with `rst` low and `core_run` stays low until the next reset.
- R8: While `rst` is high, `core_run`, `dma_start` and `boot_err` are low.
- R9: Once `core_run` is high, it stays high until reset.
- R10: `start_external` is 1 only for code 010. `start_addr` is 0 in every mode with the default vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| mode_pins | input | 3 | Strap word {C, B, A} |
| dma_done | input | 1 | Completion pulse from the byte DMA engine |
| host_wr_valid | input | 1 | A host write is present this cycle |
| host_wr_pm | input | 1 | The host write targets program memory |
| host_wr_addr | input | ADDR_W | Host write word address |
| core_run | output | 1 | Core fetch enable |
| start_addr | output | ADDR_W | First fetch address |
| start_external | output | 1 | The first fetch is from external memory |
| host_mem_mode | output | 1 | 1 = host memory mode, 0 = full memory mode |
| dma_start | output | 1 | One-cycle boot DMA start strobe |
| dma_words | output | CNT_W | Boot DMA word count |
| boot_err | output | 1 | A reserved strap code was captured |

## Verification
The assertions check the following on every cycle:
- the memory mode flag is frozen once reset is low;
- the start strobe never lasts more than one cycle;
- the run enable is sticky;
- an error never coexists with a running core;
- any non-immediate release is preceded by a DMA done or a qualifying host write.

Only the bench scenarios can show that each strap code picks the right method. They also show that pin changes after reset, stray DMA pulses and near-miss host writes leave the core held, and that release lands exactly one cycle after its trigger.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;

    localparam int PIN_W = 3;
    localparam int PIN_C = 2;
    localparam int PIN_B = 1;
    localparam int PIN_A = 0;

    typedef enum logic [1:0] {
        BOOT_BYTE_DMA = 2'd0,
        BOOT_NONE     = 2'd1,
        BOOT_HOST_DMA = 2'd2,
        BOOT_RESERVED = 2'd3
    } boot_kind_e;

    typedef struct packed {
        logic       host_mem;
        boot_kind_e kind;
    } boot_cfg_t;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_WAIT_DMA,
        ST_WAIT_HOST,
        ST_RUN,
        ST_HALT
    } seq_state_e;

    function automatic boot_cfg_t decode_straps(input logic [PIN_W-1:0] p);
        boot_cfg_t cfg;
        cfg.host_mem = p[PIN_C];
        if (!p[PIN_B] && !p[PIN_A])
            cfg.kind = BOOT_BYTE_DMA;
        else if (p[PIN_B] && !p[PIN_A] && !p[PIN_C])
            cfg.kind = BOOT_NONE;
        else if (!p[PIN_B] && p[PIN_A] && p[PIN_C])
            cfg.kind = BOOT_HOST_DMA;
        else
            cfg.kind = BOOT_RESERVED;
        return cfg;
    endfunction

endpackage

// File: rtl/boot_mode_latch.sv
`timescale 1ns/1ps
module boot_mode_latch
    import boot_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] pins_i,
    output boot_cfg_t        cfg_o
);
    logic [PIN_W-1:0] pins_q;

    // Transparent capture during reset, frozen afterwards
    always_ff @(posedge clk) begin
        if (rst)
            pins_q <= pins_i;
    end

    assign cfg_o = decode_straps(pins_q);
endmodule

// File: rtl/boot_host_watch.sv
`timescale 1ns/1ps
module boot_host_watch #(
    parameter int ADDR_W      = 14,
    parameter int TARGET_ADDR = 0
) (
    input  logic              wr_valid,
    input  logic              wr_pm,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              hit_o
);
    localparam logic [ADDR_W-1:0] TARGET = ADDR_W'(TARGET_ADDR);

    assign hit_o = wr_valid && wr_pm && (wr_addr == TARGET);
endmodule

// File: rtl/boot_seq_fsm.sv
`timescale 1ns/1ps
module boot_seq_fsm
    import boot_seq_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int INT_START = 0,
    parameter int EXT_START = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  boot_kind_e        kind_i,
    input  logic              dma_done_i,
    input  logic              host_hit_i,
    output logic              run_o,
    output logic              dma_start_o,
    output logic              err_o,
    output logic              ext_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] INT_VEC = ADDR_W'(INT_START);
    localparam logic [ADDR_W-1:0] EXT_VEC = ADDR_W'(EXT_START);

    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_RESET;
            run_o       <= 1'b0;
            dma_start_o <= 1'b0;
            err_o       <= 1'b0;
            ext_o       <= 1'b0;
            addr_o      <= INT_VEC;
        end else begin
            dma_start_o <= 1'b0;
            case (state)
                ST_RESET: begin
                    case (kind_i)
                        BOOT_BYTE_DMA: begin
                            state       <= ST_WAIT_DMA;
                            dma_start_o <= 1'b1;
                        end
                        BOOT_NONE: begin
                            state  <= ST_RUN;
                            run_o  <= 1'b1;
                            ext_o  <= 1'b1;
                            addr_o <= EXT_VEC;
                        end
                        BOOT_HOST_DMA: state <= ST_WAIT_HOST;
                        default: begin
                            state <= ST_HALT;
                            err_o <= 1'b1;
                        end
                    endcase
                end
                ST_WAIT_DMA: begin
                    if (dma_done_i) begin
                        state <= ST_RUN;
                        run_o <= 1'b1;
                    end
                end
                ST_WAIT_HOST: begin
                    if (host_hit_i) begin
                        state <= ST_RUN;
                        run_o <= 1'b1;
                    end
                end
                default: state <= state;
            endcase
        end
    end
endmodule

// File: rtl/boot_mode_seq.sv
`timescale 1ns/1ps
module boot_mode_seq
    import boot_seq_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int BOOT_WORDS = 32,
    parameter int CNT_W      = $clog2(BOOT_WORDS + 1),
    parameter int INT_START  = 0,
    parameter int EXT_START  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_pins,
    input  logic              dma_done,
    input  logic              host_wr_valid,
    input  logic              host_wr_pm,
    input  logic [ADDR_W-1:0] host_wr_addr,
    output logic              core_run,
    output logic [ADDR_W-1:0] start_addr,
    output logic              start_external,
    output logic              host_mem_mode,
    output logic              dma_start,
    output logic [CNT_W-1:0]  dma_words,
    output logic              boot_err
);
    boot_cfg_t cfg;
    logic      host_hit;

    boot_mode_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .pins_i (mode_pins),
        .cfg_o  (cfg)
    );

    boot_host_watch #(.ADDR_W(ADDR_W), .TARGET_ADDR(0)) u_watch (
        .wr_valid (host_wr_valid),
        .wr_pm    (host_wr_pm),
        .wr_addr  (host_wr_addr),
        .hit_o    (host_hit)
    );

    boot_seq_fsm #(
        .ADDR_W    (ADDR_W),
        .INT_START (INT_START),
        .EXT_START (EXT_START)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .kind_i      (cfg.kind),
        .dma_done_i  (dma_done),
        .host_hit_i  (host_hit),
        .run_o       (core_run),
        .dma_start_o (dma_start),
        .err_o       (boot_err),
        .ext_o       (start_external),
        .addr_o      (start_addr)
    );

    assign host_mem_mode = cfg.host_mem;
    assign dma_words     = CNT_W'(BOOT_WORDS);
endmodule

// File: rtl/boot_mode_seq_chk.sv
`timescale 1ns/1ps
module boot_mode_seq_chk (
    input logic clk,
    input logic rst,
    input logic core_run,
    input logic dma_start,
    input logic boot_err,
    input logic host_mem_mode,
    input logic start_external,
    input logic dma_done,
    input logic host_hit
);
    // R1: memory mode cannot move once reset has been released
    a_r1_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(host_mem_mode));

    // R3: start strobe lasts a single cycle
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        dma_start |=> !dma_start);

    // R9: run enable is sticky
    a_r9_run_sticky: assert property (@(posedge clk) disable iff (rst)
        core_run |=> core_run);

    // R7: an error never coexists with a running core
    a_r7_err_no_run: assert property (@(posedge clk) disable iff (rst)
        boot_err |-> !core_run);

    // R4 and R6: a held release is caused by DMA done or a host hit
    a_r4_release_cause: assert property (@(posedge clk) disable iff (rst)
        ($rose(core_run) && !start_external) |-> ($past(dma_done) || $past(host_hit)));

    // R5: no-boot start neither strobes the DMA nor flags an error
    a_r5_noboot_quiet: assert property (@(posedge clk) disable iff (rst)
        start_external |-> (!dma_start && !boot_err));
endmodule

bind boot_mode_seq boot_mode_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .core_run       (core_run),
    .dma_start      (dma_start),
    .boot_err       (boot_err),
    .host_mem_mode  (host_mem_mode),
    .start_external (start_external),
    .dma_done       (dma_done),
    .host_hit       (host_hit)
);

// File: tb/boot_mode_seq_test.sv
`timescale 1ns/1ps
module boot_mode_seq_test;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    mode_pins = 3'b000;
    logic          dma_done = 1'b0;
    logic          host_wr_valid = 1'b0;
    logic          host_wr_pm = 1'b0;
    logic [AW-1:0] host_wr_addr = '0;
    logic          core_run, start_external, host_mem_mode, dma_start, boot_err;
    logic [AW-1:0] start_addr;
    logic [5:0]    dma_words;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    boot_mode_seq uut (
        .clk(clk), .rst(rst), .mode_pins(mode_pins), .dma_done(dma_done),
        .host_wr_valid(host_wr_valid), .host_wr_pm(host_wr_pm),
        .host_wr_addr(host_wr_addr), .core_run(core_run), .start_addr(start_addr),
        .start_external(start_external), .host_mem_mode(host_mem_mode),
        .dma_start(dma_start), .dma_words(dma_words), .boot_err(boot_err)
    );

    // bench model: 0 byte DMA, 1 no boot, 2 host DMA, 3 reserved
    function automatic int exp_kind(input logic [2:0] c);
        case (c)
            3'b000, 3'b100: return 0;
            3'b010:         return 1;
            3'b101:         return 2;
            default:        return 3;
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        dma_done = 1'b0;
        host_wr_valid = 1'b0;
        host_wr_pm = 1'b0;
        host_wr_addr = '0;
    endtask

    task automatic run_case(input logic [2:0] code, input int unsigned wait_n);
        int k;
        k = exp_kind(code);
        clear_in();
        rst = 1'b1;
        mode_pins = code;
        step(); step(); step();
        chk("R8 run in reset", core_run, 0);
        chk("R8 strobe in reset", dma_start, 0);
        chk("R8 err in reset", boot_err, 0);
        chk("R2 host mode", host_mem_mode, code[2]);
        rst = 1'b0;
        mode_pins = ~code;
        step();
        chk("R3 strobe after reset", dma_start, k == 0);
        chk("R5 immediate run", core_run, k == 1);
        chk("R7 error flag", boot_err, k == 3);
        chk("R10 external start", start_external, k == 1);
        chk("R10 start addr", start_addr, 0);
        chk("R3 word count", dma_words, 32);
        chk("R1 pins frozen", host_mem_mode, code[2]);
        mode_pins = $urandom();
        step();
        chk("R3 strobe ends", dma_start, 0);
        for (int i = 0; i < int'(wait_n); i++) begin
            if (k == 0) begin
                host_wr_valid = 1'b1; host_wr_pm = 1'b1; host_wr_addr = '0;
            end else begin
                case ($urandom_range(0, 2))
                    0: dma_done = 1'b1;
                    1: begin
                        host_wr_valid = 1'b1; host_wr_pm = 1'b1;
                        host_wr_addr = AW'($urandom_range(1, 16383));
                    end
                    default: begin
                        host_wr_valid = 1'b1; host_wr_pm = 1'b0; host_wr_addr = '0;
                    end
                endcase
            end
            step();
            clear_in();
            chk(k == 0 ? "R4 held" : (k == 2 ? "R6 held" : (k == 1 ? "R5 ignored" : "R7 held")),
                core_run, k == 1);
            chk("R1 pins frozen", host_mem_mode, code[2]);
        end
        if (k == 0) begin
            dma_done = 1'b1;
        end else if (k == 2) begin
            host_wr_valid = 1'b1; host_wr_pm = 1'b1; host_wr_addr = '0;
        end else begin
            dma_done = 1'b1;
            host_wr_valid = 1'b1; host_wr_pm = 1'b1; host_wr_addr = '0;
        end
        step();
        clear_in();
        chk(k == 0 ? "R4 release" : (k == 2 ? "R6 release" : (k == 1 ? "R5 run" : "R7 stays held")),
            core_run, k != 3);
        chk("R7 error stays", boot_err, k == 3);
        step(); step();
        chk("R9 run sticky", core_run, k != 3);
        chk("R5 no strobe later", dma_start, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_B007));
        for (int c = 0; c < 8; c++) run_case(3'(c), 3);
        // directed: release on the very first waiting cycle
        run_case(3'b000, 0);
        run_case(3'b101, 0);
        for (int n = 0; n < 30; n++) run_case(3'($urandom_range(0, 7)), $urandom_range(0, 6));
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule